// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The controller gathers 32 interrupt inputs. Each input has its own trigger type, priority level and vector word. One active-low interrupt line goes to a processor. Software reads the vector port, which returns the vector word of the best waiting source. That read also marks the source as taken and pushes its level onto an internal stack of eight entries. Once servicing is done, software writes the end-of-service port, which pops one level. While a level is on the stack, only a strictly more urgent source can pull the line low again, so handlers nest cleanly.

All access goes through a plain register bus. Reads are combinational and writes take effect on a clock edge. Addresses are byte offsets whose two low bits are ignored. Software gets per-source mode and vector words, write-one command ports that enable, disable, set or clear sources, and read ports for the enable mask, the raw pending bits, the current source and the line state. A build-time mask, `EXT_MASK`, marks which sources come from package pins. Only those sources may use low-level or falling-edge triggering.

Control is a two-state machine, with the states named ST_QUIET and ST_NESTED:
- ST_QUIET means no source is being serviced. In this state any pending enabled source drives the line.
- ST_NESTED means at least one level is on the stack.
- The transition ACK (a vector read that finds a qualifying source) moves from ST_QUIET to ST_NESTED.
- The transition RETIRE (an end-of-service write that empties the stack) moves back to ST_QUIET.
- Further ACKs and non-final end-of-service writes leave the state in ST_NESTED and change only the stack depth.

Top module: `pvic_top`

## Requirements
- R1: After reset:
  - the enable mask (0x110) and the pending bits (0x10C) read 0, once inputs have settled to their idle levels;
  - `irq_n` is 1;
  - the current-source port (0x108) reads 0;
  - the spurious vector (0x134) reads 0;
  - every mode word holds priority 0, with trigger type 0 for external sources and type 2 for internal ones.
- R2: The mode word at 4·n holds the priority in bits 2:0 (0 lowest, 7 highest) and the trigger type in bits 6:5. The type codes are 0 low level, 1 falling edge, 2 high level and 3 rising edge. On an internal source, a written type of 0 or 1 is stored as 2 or 3. The vector word of source n sits at 0x80+4·n.
- R3: Edge sources latch a pending bit on the selected edge of their input after a two-flop synchronizer. The opposite edge does not latch. Level sources are pending for as long as the synchronized input is at its active level.
- R4: A write to 0x120 sets mask bits and a write to 0x124 clears them, one bit per source where the data bit is 1. A write to 0x12C sets latched pending bits and a write to 0x128 clears them in the same way.
- R5: Among pending enabled sources, the highest priority wins. When priorities tie, the lowest source number wins.
- R6: `irq_n` is 0 exactly when a pending enabled source exists and either the stack is empty or the winner's priority is strictly greater than the stack top.
- R7: A read of 0x100 while `irq_n` is 0 has three effects. It returns the winner's vector word, it pushes the winner's level and number, and it clears the winner's latched pending bit. After that, 0x108 reports the winner's number.
- R8: A read of 0x100 while `irq_n` is 1 returns the spurious vector word written at 0x134 and leaves the stack unchanged.
- R9: Any write to 0x130 pops one stack level, whatever the data. Up to 8 levels nest. A write to 0x130 with an empty stack has no effect, so eight writes always leave the line free. Reading 0x108 returns the source number at the stack top, or 0 when the stack is empty.
- R10: The port 0x114 reads bit 1 as 1 while `irq_n` is 0. Bit 0, the fast line, always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Raw interrupt inputs, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; needed for the side effects of reading the vector port |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
The hardest state to reach is a full eight-level stack. Filling it needs eight sources, each more urgent than the previous one, and each acknowledged before the next one fires. The bench gives sources 0 to 7 the priorities 0 to 7 and raises them one at a time in ascending order, reading the vector after each. It then raises a priority-0 source, which must stay blocked, and unwinds the stack while checking the reported source at every pop. Arbitration is swept over every pair of sources fired together. The priority of each source is its number mod 8, so the bench predicts the winner by arithmetic.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    typedef enum logic [1:0] {
        TRG_LOW  = 2'd0,
        TRG_FALL = 2'd1,
        TRG_HIGH = 2'd2,
        TRG_RISE = 2'd3
    } trig_e;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_NESTED = 1'b1
    } ctl_state_e;

    localparam logic [8:0] OFS_VECTOR  = 9'h100;
    localparam logic [8:0] OFS_CURSRC  = 9'h108;
    localparam logic [8:0] OFS_PENDING = 9'h10C;
    localparam logic [8:0] OFS_MASK    = 9'h110;
    localparam logic [8:0] OFS_LINES   = 9'h114;
    localparam logic [8:0] OFS_ENABLE  = 9'h120;
    localparam logic [8:0] OFS_DISABLE = 9'h124;
    localparam logic [8:0] OFS_CLEAR   = 9'h128;
    localparam logic [8:0] OFS_SET     = 9'h12C;
    localparam logic [8:0] OFS_DONE    = 9'h130;
    localparam logic [8:0] OFS_SPUR    = 9'h134;

endpackage

// File: rtl/pvic_src_cond.sv
module pvic_src_cond
    import pvic_pkg::*;
#(
    parameter int unsigned NSRC = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       src_i,
    input  logic [NSRC-1:0][1:0]  trig,
    input  logic [NSRC-1:0]       set_v,
    input  logic [NSRC-1:0]       clr_v,
    input  logic [NSRC-1:0]       ack_v,
    output logic [NSRC-1:0]       pend_o
);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic meta_q, sync_q, prev_q, latch_q;
        logic edge_hit, level_hit;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q  <= 1'b0;
                sync_q  <= 1'b0;
                prev_q  <= 1'b0;
                latch_q <= 1'b0;
            end else begin
                meta_q  <= src_i[g];
                sync_q  <= meta_q;
                prev_q  <= sync_q;
                latch_q <= (latch_q & ~(clr_v[g] | ack_v[g])) | set_v[g] | edge_hit;
            end
        end

        always_comb begin
            edge_hit  = 1'b0;
            level_hit = 1'b0;
            unique case (trig_e'(trig[g]))
                TRG_LOW:  level_hit = ~sync_q;
                TRG_FALL: edge_hit  = prev_q & ~sync_q;
                TRG_HIGH: level_hit = sync_q;
                TRG_RISE: edge_hit  = sync_q & ~prev_q;
            endcase
        end

        assign pend_o[g] = latch_q | level_hit;
    end

endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
    parameter int unsigned NSRC = 32,
    parameter int unsigned PW   = 3,
    localparam int unsigned IW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]          cand,
    input  logic [NSRC-1:0][PW-1:0]  prio,
    output logic                     valid,
    output logic [IW-1:0]            id,
    output logic [PW-1:0]            lvl
);

    // Descending scan with >= lets the lowest index win a tie.
    always_comb begin
        valid = 1'b0;
        id    = '0;
        lvl   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i] && (!valid || prio[i] >= lvl)) begin
                valid = 1'b1;
                id    = IW'(i);
                lvl   = prio[i];
            end
        end
    end

endmodule

// File: rtl/pvic_lvl_stack.sv
module pvic_lvl_stack #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned PW    = 3,
    parameter int unsigned IW    = 5,
    localparam int unsigned DW   = $clog2(DEPTH + 1),
    localparam int unsigned PTRW = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    input  logic [PW-1:0]  push_lvl,
    input  logic [IW-1:0]  push_id,
    output logic [PW-1:0]  top_lvl,
    output logic [IW-1:0]  top_id,
    output logic [DW-1:0]  depth,
    output logic           full
);

    logic [DEPTH-1:0][PW-1:0] lvl_q;
    logic [DEPTH-1:0][IW-1:0] id_q;
    logic [DW-1:0]            cnt_q;
    logic [DW-1:0]            top_ptr;

    assign top_ptr = cnt_q - 1'b1;
    assign top_lvl = lvl_q[top_ptr[PTRW-1:0]];
    assign top_id  = id_q[top_ptr[PTRW-1:0]];
    assign depth   = cnt_q;
    assign full    = (cnt_q == DW'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            id_q  <= '0;
            cnt_q <= '0;
        end else if (push && !full) begin
            lvl_q[cnt_q[PTRW-1:0]] <= push_lvl;
            id_q[cnt_q[PTRW-1:0]]  <= push_id;
            cnt_q <= cnt_q + 1'b1;
        end else if (pop && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
#(
    parameter int unsigned     NSRC     = 32,
    parameter int unsigned     PW       = 3,
    parameter int unsigned     DEPTH    = 8,
    parameter int unsigned     BW       = 32,
    parameter int unsigned     AW       = 9,
    parameter logic [NSRC-1:0] EXT_MASK = 32'hF000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [AW-1:0]   bus_addr,
    input  logic [BW-1:0]   bus_wdata,
    output logic [BW-1:0]   bus_rdata,
    output logic            irq_n
);

    localparam int unsigned IW = $clog2(NSRC);
    localparam int unsigned DW = $clog2(DEPTH + 1);

    logic [NSRC-1:0][PW-1:0] prio_q;
    logic [NSRC-1:0][1:0]    trig_q;
    logic [NSRC-1:0][BW-1:0] vec_q;
    logic [NSRC-1:0]         imr_q;
    logic [BW-1:0]           spu_q;

    logic [IW-1:0] sel_idx;
    logic          hit_mode, hit_vec;
    logic [AW-1:0] word_addr;
    logic [1:0]    wr_trig;

    assign word_addr = {bus_addr[AW-1:2], 2'b00};
    assign sel_idx   = bus_addr[IW+1:2];
    assign hit_mode  = (bus_addr[AW-1:7] == '0);
    assign hit_vec   = (bus_addr[AW-1:7] == (AW-7)'(1));
    assign wr_trig   = EXT_MASK[sel_idx] ? bus_wdata[6:5] : {1'b1, bus_wdata[5]};

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) begin
                prio_q[i] <= '0;
                trig_q[i] <= EXT_MASK[i] ? 2'(TRG_LOW) : 2'(TRG_HIGH);
                vec_q[i]  <= '0;
            end
            imr_q <= '0;
            spu_q <= '0;
        end else if (bus_wr) begin
            if (hit_mode) begin
                prio_q[sel_idx] <= bus_wdata[PW-1:0];
                trig_q[sel_idx] <= wr_trig;
            end
            if (hit_vec) vec_q[sel_idx] <= bus_wdata;
            if (word_addr == OFS_ENABLE)  imr_q <= imr_q | bus_wdata[NSRC-1:0];
            if (word_addr == OFS_DISABLE) imr_q <= imr_q & ~bus_wdata[NSRC-1:0];
            if (word_addr == OFS_SPUR)    spu_q <= bus_wdata;
        end
    end

    // conditioning, arbitration, stack
    logic [NSRC-1:0] set_v, clr_v, ack_v, pend, cand;
    logic            win_valid;
    logic [IW-1:0]   win_id;
    logic [PW-1:0]   win_lvl;
    logic [PW-1:0]   top_lvl;
    logic [IW-1:0]   top_id;
    logic [DW-1:0]   depth;
    logic            full;
    logic            exceed, ack, pop, ivr_rd, eoi_wr;

    assign set_v  = (bus_wr && word_addr == OFS_SET)   ? bus_wdata[NSRC-1:0] : '0;
    assign clr_v  = (bus_wr && word_addr == OFS_CLEAR) ? bus_wdata[NSRC-1:0] : '0;
    assign ack_v  = ack ? (NSRC'(1) << win_id) : '0;
    assign cand   = pend & imr_q;
    assign ivr_rd = bus_rd && word_addr == OFS_VECTOR;
    assign eoi_wr = bus_wr && word_addr == OFS_DONE;

    pvic_src_cond #(.NSRC(NSRC)) u_cond (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .trig(trig_q),
        .set_v(set_v), .clr_v(clr_v), .ack_v(ack_v), .pend_o(pend)
    );

    pvic_arbiter #(.NSRC(NSRC), .PW(PW)) u_arb (
        .cand(cand), .prio(prio_q), .valid(win_valid), .id(win_id), .lvl(win_lvl)
    );

    pvic_lvl_stack #(.DEPTH(DEPTH), .PW(PW), .IW(IW)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(ack), .pop(pop),
        .push_lvl(win_lvl), .push_id(win_id),
        .top_lvl(top_lvl), .top_id(top_id), .depth(depth), .full(full)
    );

    // control state machine
    ctl_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_QUIET;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_QUIET:  if (ack) st_d = ST_NESTED;
            ST_NESTED: if (pop && depth == DW'(1)) st_d = ST_QUIET;
        endcase
    end

    always_comb begin
        exceed = 1'b0;
        pop    = 1'b0;
        unique case (st_q)
            ST_QUIET:  exceed = win_valid;
            ST_NESTED: begin
                exceed = win_valid && (win_lvl > top_lvl);
                pop    = eoi_wr && !ack;
            end
        endcase
    end

    assign ack   = ivr_rd && exceed;
    assign irq_n = ~exceed;

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (hit_mode) begin
            bus_rdata[PW-1:0] = prio_q[sel_idx];
            bus_rdata[6:5]    = trig_q[sel_idx];
        end else if (hit_vec) begin
            bus_rdata = vec_q[sel_idx];
        end else begin
            unique case (word_addr)
                OFS_VECTOR:  bus_rdata = exceed ? vec_q[win_id] : spu_q;
                OFS_CURSRC:  bus_rdata[IW-1:0] = (st_q == ST_NESTED) ? top_id : '0;
                OFS_PENDING: bus_rdata[NSRC-1:0] = pend;
                OFS_MASK:    bus_rdata[NSRC-1:0] = imr_q;
                OFS_LINES:   bus_rdata[1:0] = {exceed, 1'b0};
                OFS_SPUR:    bus_rdata = spu_q;
                default:     bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pvic_checker.sv
module pvic_checker #(
    parameter int unsigned DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_n,
    input logic          ack,
    input logic          pop,
    input logic          ivr_rd,
    input logic          full,
    input logic          nested,
    input logic          cand_any,
    input logic [DW-1:0] depth
);

    a_r7_ack_pushes: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> depth == DW'($past(depth) + 1'b1));

    a_r9_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> depth == DW'($past(depth) - 1'b1));

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !full);

    a_r9_state_tracks_depth: assert property (@(posedge clk) disable iff (!rst_n)
        nested == (depth != '0));

    a_r6_line_needs_candidate: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> cand_any);

    a_r8_spurious_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (ivr_rd && irq_n && !pop) |=> $stable(depth));

endmodule

bind pvic_top pvic_checker #(.DW(DW)) u_pvic_checker (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .ack(ack), .pop(pop),
    .ivr_rd(ivr_rd), .full(full), .nested(st_q == ST_NESTED),
    .cand_any(cand != '0), .depth(depth)
);

// File: tb/test_pvic_top.sv
module test_pvic_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_n;

    localparam logic [31:0] EXT = 32'hF000_0000;
    localparam logic [31:0] IDLE = EXT;

    int checks = 0;
    int fails  = 0;

    pvic_top i_pvic_top (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [8:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic pulse(input logic [31:0] m);
        @(negedge clk);
        src_i = src_i ^ m;
        repeat (2) @(negedge clk);
        src_i = src_i ^ m;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] vec_of(input int n);
        return 32'h0000_0400 + n;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        src_i = IDLE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        rdchk("R1 mask", 9'h110, 32'h0);
        rdchk("R1 pending", 9'h10C, 32'h0);
        chk("R1 irq_n", {31'h0, irq_n}, 32'h1);
        rdchk("R1 cursrc", 9'h108, 32'h0);
        rdchk("R1 spurious", 9'h134, 32'h0);
        rdchk("R1 mode internal", 9'h000, 32'h40);
        rdchk("R1 mode external", 9'h07C, 32'h00);
        rdchk("R8 vector idle", 9'h100, 32'h0);
        rdchk("R10 lines idle", 9'h114, 32'h0);

        // R2 mode fields and internal coercion
        wr(9'h00C, 32'h05);  rdchk("R2 coerce low", 9'h00C, 32'h45);
        wr(9'h00C, 32'h25);  rdchk("R2 coerce fall", 9'h00C, 32'h65);
        wr(9'h078, 32'h25);  rdchk("R2 external fall", 9'h078, 32'h25);
        wr(9'h014, 32'hFFFF_FFFF); rdchk("R2 unused bits", 9'h014, 32'h67);

        // configure: priority n mod 8, rising internal / falling external
        for (int i = 0; i < 32; i++) begin
            wr(9'(4 * i), (EXT[i] ? 32'h20 : 32'h60) | 32'(i % 8));
            wr(9'(9'h80 + 4 * i), vec_of(i));
        end
        rdchk("R2 vector word", 9'h80 + 9'd44, vec_of(11));
        wr(9'h120, 32'hFFFF_FFFF);
        rdchk("R4 mask all", 9'h110, 32'hFFFF_FFFF);

        // R5 pair sweep
        for (int a = 0; a < 32; a++) begin
            for (int b = a + 1; b < 32; b++) begin
                int w, o;
                w = ((b % 8) > (a % 8)) ? b : a;
                o = (w == a) ? b : a;
                pulse((32'h1 << a) | (32'h1 << b));
                chk("R3 both latched", {31'h0, irq_n}, 32'h0);
                rdchk("R5 winner", 9'h100, vec_of(w));
                rdchk("R7 cursrc", 9'h108, 32'(w));
                chk("R6 blocked", {31'h0, irq_n}, 32'h1);
                wr(9'h130, 32'h0);
                chk("R6 reopen", {31'h0, irq_n}, 32'h0);
                rdchk("R5 loser", 9'h100, vec_of(o));
                wr(9'h130, 32'h0);
                rdchk("R3 no opposite edge", 9'h10C, 32'h0);
            end
        end

        // R9 full nesting
        for (int k = 0; k < 8; k++) begin
            pulse(32'h1 << k);
            chk("R6 higher preempts", {31'h0, irq_n}, 32'h0);
            rdchk("R7 nest vector", 9'h100, vec_of(k));
        end
        rdchk("R9 top", 9'h108, 32'd7);
        pulse(32'h1 << 8);
        chk("R6 low blocked", {31'h0, irq_n}, 32'h1);
        rdchk("R8 spurious under nest", 9'h100, 32'h0);
        for (int k = 7; k >= 0; k--) begin
            rdchk("R9 unwind top", 9'h108, 32'(k));
            wr(9'h130, 32'hDEAD_BEEF);
        end
        chk("R9 unlocked", {31'h0, irq_n}, 32'h0);
        rdchk("R7 after unwind", 9'h100, vec_of(8));
        for (int k = 0; k < 9; k++) wr(9'h130, 32'h0);
        rdchk("R9 empty cursrc", 9'h108, 32'h0);
        chk("R9 idle line", {31'h0, irq_n}, 32'h1);

        // R4 mask, R8 spurious, R10 lines
        wr(9'h134, 32'h0000_DEAD);
        wr(9'h124, 32'h20);
        rdchk("R4 disable", 9'h110, 32'hFFFF_FFDF);
        pulse(32'h20);
        rdchk("R4 masked pending", 9'h10C, 32'h20);
        chk("R6 masked", {31'h0, irq_n}, 32'h1);
        rdchk("R8 spurious", 9'h100, 32'h0000_DEAD);
        rdchk("R8 cursrc", 9'h108, 32'h0);
        rdchk("R10 line off", 9'h114, 32'h0);
        wr(9'h120, 32'h20);
        chk("R4 enable", {31'h0, irq_n}, 32'h0);
        rdchk("R10 line on", 9'h114, 32'h2);
        wr(9'h128, 32'h20);
        rdchk("R4 clear", 9'h10C, 32'h0);
        chk("R4 clear line", {31'h0, irq_n}, 32'h1);
        wr(9'h12C, 32'h200);
        chk("R4 set", {31'h0, irq_n}, 32'h0);
        rdchk("R4 set vector", 9'h100, vec_of(9));
        wr(9'h130, 32'h0);

        // R3 level sources
        wr(9'h014, 32'h43);
        @(negedge clk); src_i[5] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 high level", {31'h0, irq_n}, 32'h0);
        rdchk("R7 level vector", 9'h100, vec_of(5));
        chk("R6 same level blocked", {31'h0, irq_n}, 32'h1);
        wr(9'h130, 32'h0);
        chk("R3 level persists", {31'h0, irq_n}, 32'h0);
        @(negedge clk); src_i[5] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 level drops", {31'h0, irq_n}, 32'h1);
        rdchk("R3 level pending clear", 9'h10C, 32'h0);
        wr(9'h074, 32'h02);
        @(negedge clk); src_i[29] = 1'b0;
        repeat (3) @(negedge clk);
        rdchk("R3 low level", 9'h10C, 32'h2000_0000);
        chk("R3 low level line", {31'h0, irq_n}, 32'h0);
        @(negedge clk); src_i[29] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 low level idle", {31'h0, irq_n}, 32'h1);

        summary();
        $finish;
    end

endmodule